// File: doc/BRIEF.md
# Microinstruction Store Parity and Breakpoint Unit

This block holds a microinstruction store whose words are split into two halves of 17 data bits, each stored with its own parity bit. When a word is written, the parity bit of each half is not recomputed from the data. It is formed from the two byte-parity bits that arrive with the data, together with the extra seventeenth bit. A per-half write option deliberately stores the wrong parity. Software uses this to plant breakpoints: a word whose two halves both fail is read as a breakpoint, not as a fault.

Words are fetched into an instruction register on a `t2_strobe` pulse. A parity ladder on each half of that register reports failures continuously (the live error bits). At the next strobe, which ends the instruction, those failures are captured into sticky status. Captured failures raise a halt request, with a separate enable for each half. An optional debug mode keeps the instruction register from being overwritten while it holds a failing word, so the word can be inspected. Every other strobe action still takes place.

Top module: `ucs_parity_bkpt`

## Requirements
- R1: With correct odd byte parity supplied, a stored and reloaded word appears unchanged on `ir_data` and `live_err` reads 0. Half h is `wr_data[17h+16:17h]`. Its low byte is bits 7:0 of the half and its high byte is bits 15:8. The byte parity bits are `wr_bpar[2h]` for the low byte and `wr_bpar[2h+1]` for the high byte, and each makes its byte plus itself odd.
- R2: Setting `wr_force_bad[h]` during a write stores parity of the wrong sense for half h only, so `live_err[h]` reads 1 once the word is loaded.
- R3: The stored parity follows the supplied byte parity bits. A wrong `wr_bpar` bit for half h makes that half fail on load, and a force combined with one wrong bit in the same half cancels out.
- R4: `live_err` follows the word currently held in the instruction register with no delay. `err_latched` and `bkpt_latched` change only on a `t2_strobe` or on `clr_status`.
- R5: On a strobe, a failing half that is not part of a double failure sets its bit in `err_latched`. The bit holds until `clr_status`, and `clr_status` wins over a capture in the same cycle.
- R6: On a strobe where both halves fail, `bkpt_latched` is set and `err_latched` is left unchanged.
- R7: `halt` is high when a latched single-half error has its `halt_en` bit set, or when `bkpt_latched` is set and any `halt_en` bit is set. It is low otherwise.
- R8: While `dbg_mode` is 1 and `live_err` is nonzero, a strobe leaves the instruction register unchanged but still captures status. With `dbg_mode` at 0, every strobe loads the register.
- R9: `dbg_set` sets `dbg_mode` and `dbg_clr` clears it. When both are asserted in the same cycle, `dbg_clr` wins.
- R10: After reset the instruction register holds all-zero data with valid parity, and `live_err`, `err_latched`, `bkpt_latched`, `halt` and `dbg_mode` are all 0.
- R11: A write to the store does not change the instruction register. A rewritten word appears only on the next strobe that fetches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a word into the store |
| wr_addr | input | 6 | Write address |
| wr_data | input | 34 | Two 17-bit halves, half 0 in bits 16:0 |
| wr_bpar | input | 4 | Odd byte parity, two bits per half |
| wr_force_bad | input | 2 | Store parity of the wrong sense for each half |
| rd_addr | input | 6 | Word fetched on the next strobe |
| t2_strobe | input | 1 | Ends the current instruction and loads the next |
| halt_en | input | 2 | Per-half halt enables |
| clr_status | input | 1 | Clears latched error and breakpoint status |
| dbg_set | input | 1 | Enters debug freeze mode |
| dbg_clr | input | 1 | Leaves debug freeze mode |
| ir_data | output | 34 | Instruction register data |
| live_err | output | 2 | Unbuffered per-half parity failure |
| err_latched | output | 2 | Sticky single-half failures captured at a strobe |
| bkpt_latched | output | 1 | Sticky double-failure (breakpoint) indication |
| halt | output | 1 | Halt request |
| dbg_mode | output | 1 | Debug freeze mode is active |

## Verification
On every cycle, the assertions check the following: status is sticky and moves only on a strobe or a clear; a clear empties it; a double failure at a strobe becomes a breakpoint; halt stays low with no enable or no status; the register holds between strobes and under freeze; and the mode bit responds to set and clear. Only the bench scenarios can show the parity arithmetic itself. That covers correct stored parity for many data patterns, the forcing of a single half, the effect of a wrong byte parity bit and its cancellation by a force, the one-strobe delay between loading a bad word and latching it, and a rewritten word appearing on the next fetch.

// File: rtl/ucs_par_pkg.sv
package ucs_par_pkg;

   // The word is always split in two halves; a breakpoint needs both.
   localparam int unsigned NHALF          = 2;
   // Each half carries two bytes plus one extra bit.
   localparam int unsigned BYTES_PER_HALF = 2;

   typedef logic [NHALF-1:0] half_vec_t;

   typedef struct packed {
      half_vec_t err;   // sticky single-half failures
      logic      bkpt;  // sticky double failure
   } ucs_stat_t;

endpackage

// File: rtl/ucs_wr_pargen.sv
module ucs_wr_pargen
   import ucs_par_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned HALF_W = BYTES_PER_HALF * BYTE_W + 1,
   localparam int unsigned SLOT_W = HALF_W + 1,
   localparam int unsigned DATA_W = NHALF * HALF_W,
   localparam int unsigned WORD_W = NHALF * SLOT_W
)(
   input  logic [DATA_W-1:0]               data,
   input  logic [NHALF*BYTES_PER_HALF-1:0] bpar,
   input  logic [NHALF-1:0]                force_bad,
   output logic [WORD_W-1:0]               word
);

   // Per half: the byte parity bits are odd, so their XOR with the extra
   // bit is the XOR of all data bits inverted twice; complementing it gives
   // the odd parity over the whole half. A force flips it once more.
   for (genvar h = 0; h < NHALF; h++) begin : g_half
      logic [HALF_W-1:0] half_data;
      logic              extra_bit;
      logic              par_bit;

      assign half_data = data[h*HALF_W +: HALF_W];
      assign extra_bit = half_data[HALF_W-1];
      assign par_bit   = ~(bpar[h*BYTES_PER_HALF] ^ bpar[h*BYTES_PER_HALF+1] ^ extra_bit)
                         ^ force_bad[h];

      assign word[h*SLOT_W +: SLOT_W] = {par_bit, half_data};
   end

endmodule

// File: rtl/ucs_store.sv
module ucs_store #(
   parameter int unsigned WORD_W = 36,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_word;
      end
   end

   // Read is asynchronous; the fetched word is captured by the register stage.
   assign rd_word = mem[rd_addr];

endmodule

// File: rtl/ucs_ir_stage.sv
module ucs_ir_stage
   import ucs_par_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter bit          FREEZE_EN = 1'b1,
   localparam int unsigned HALF_W   = BYTES_PER_HALF * BYTE_W + 1,
   localparam int unsigned SLOT_W   = HALF_W + 1,
   localparam int unsigned DATA_W   = NHALF * HALF_W,
   localparam int unsigned WORD_W   = NHALF * SLOT_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              t2_strobe,
   input  logic              dbg_set,
   input  logic              dbg_clr,
   input  logic [WORD_W-1:0] rd_word,
   output logic [DATA_W-1:0] ir_data,
   output half_vec_t         live_err,
   output logic              dbg_mode
);

   // Reset value: zero data with the parity bit set in every half.
   function automatic logic [WORD_W-1:0] clean_word();
      logic [WORD_W-1:0] w;
      w = '0;
      for (int h = 0; h < int'(NHALF); h++) begin
         w[h*SLOT_W + HALF_W] = 1'b1;
      end
      return w;
   endfunction

   localparam logic [WORD_W-1:0] IR_RESET = clean_word();

   logic [WORD_W-1:0] ir_q;
   logic              load_ok;

   // Parity ladders over each half of the held word (unbuffered).
   for (genvar h = 0; h < NHALF; h++) begin : g_ladder
      logic [SLOT_W-1:0] slot;
      assign slot        = ir_q[h*SLOT_W +: SLOT_W];
      assign live_err[h] = ~(^slot);
      assign ir_data[h*HALF_W +: HALF_W] = slot[HALF_W-1:0];
   end

   // Variant choice: with the freeze feature present, a mode register gates
   // the load; without it the register always loads on the strobe.
   if (FREEZE_EN) begin : g_freeze
      logic mode_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q <= 1'b0;
         end else if (dbg_clr) begin
            mode_q <= 1'b0;
         end else if (dbg_set) begin
            mode_q <= 1'b1;
         end
      end

      assign dbg_mode = mode_q;
      assign load_ok  = !(mode_q && (live_err != '0));
   end else begin : g_nofreeze
      logic unused_ctl;
      assign unused_ctl = dbg_set ^ dbg_clr;
      assign dbg_mode   = 1'b0;
      assign load_ok    = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_q <= IR_RESET;
      end else if (t2_strobe && load_ok) begin
         ir_q <= rd_word;
      end
   end

endmodule

// File: rtl/ucs_status.sv
module ucs_status
   import ucs_par_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      t2_strobe,
   input  logic      clr_status,
   input  half_vec_t live_err,
   input  half_vec_t halt_en,
   output ucs_stat_t stat,
   output logic      halt
);

   ucs_stat_t stat_q;
   logic      both_bad;

   assign both_bad = &live_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else if (clr_status) begin
         stat_q <= '0;
      end else if (t2_strobe) begin
         if (both_bad) begin
            stat_q.bkpt <= 1'b1;
         end else begin
            stat_q.err <= stat_q.err | live_err;
         end
      end
   end

   assign stat = stat_q;
   assign halt = (|(stat_q.err & halt_en)) | (stat_q.bkpt & (|halt_en));

endmodule

// File: rtl/ucs_parity_bkpt.sv
module ucs_parity_bkpt
   import ucs_par_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned DEPTH     = 64,
   parameter bit          FREEZE_EN = 1'b1,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned HALF_W   = BYTES_PER_HALF * BYTE_W + 1,
   localparam int unsigned DATA_W   = NHALF * HALF_W,
   localparam int unsigned WORD_W   = NHALF * (HALF_W + 1),
   localparam int unsigned BP_W     = NHALF * BYTES_PER_HALF
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BP_W-1:0]   wr_bpar,
   input  logic [NHALF-1:0]  wr_force_bad,
   input  logic [AW-1:0]     rd_addr,
   input  logic              t2_strobe,
   input  logic [NHALF-1:0]  halt_en,
   input  logic              clr_status,
   input  logic              dbg_set,
   input  logic              dbg_clr,
   output logic [DATA_W-1:0] ir_data,
   output logic [NHALF-1:0]  live_err,
   output logic [NHALF-1:0]  err_latched,
   output logic              bkpt_latched,
   output logic              halt,
   output logic              dbg_mode
);

   // Elaboration-time parameter checks.
   if (BYTE_W < 1) begin : g_bad_byte
      $error("ucs_parity_bkpt: BYTE_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("ucs_parity_bkpt: DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] rd_word;
   ucs_stat_t         stat;

   ucs_wr_pargen #(.BYTE_W(BYTE_W)) i_pargen (
      .data      (wr_data),
      .bpar      (wr_bpar),
      .force_bad (wr_force_bad),
      .word      (wr_word)
   );

   ucs_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_word (wr_word),
      .rd_addr (rd_addr),
      .rd_word (rd_word)
   );

   ucs_ir_stage #(.BYTE_W(BYTE_W), .FREEZE_EN(FREEZE_EN)) i_ir (
      .clk       (clk),
      .rst_n     (rst_n),
      .t2_strobe (t2_strobe),
      .dbg_set   (dbg_set),
      .dbg_clr   (dbg_clr),
      .rd_word   (rd_word),
      .ir_data   (ir_data),
      .live_err  (live_err),
      .dbg_mode  (dbg_mode)
   );

   ucs_status i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .t2_strobe  (t2_strobe),
      .clr_status (clr_status),
      .live_err   (live_err),
      .halt_en    (halt_en),
      .stat       (stat),
      .halt       (halt)
   );

   assign err_latched  = stat.err;
   assign bkpt_latched = stat.bkpt;

endmodule

// File: rtl/ucs_parity_bkpt_chk.sv
module ucs_parity_bkpt_chk #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned DATA_W = 2 * (2 * BYTE_W + 1)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              t2_strobe,
   input logic              clr_status,
   input logic              dbg_set,
   input logic              dbg_clr,
   input logic [1:0]        halt_en,
   input logic [1:0]        live_err,
   input logic [1:0]        err_latched,
   input logic              bkpt_latched,
   input logic              halt,
   input logic              dbg_mode,
   input logic [DATA_W-1:0] ir_data
);

   // R4: status moves only on a strobe or a clear
   a_r4_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!t2_strobe && !clr_status) |=> ($stable(err_latched) && $stable(bkpt_latched)));

   // R5: latched bits are never dropped without a clear
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_status |=> ((err_latched & $past(err_latched)) == $past(err_latched)));

   // R5: a clear empties all status
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_status |=> (err_latched == 2'b00 && !bkpt_latched));

   // R6: a double failure at a strobe becomes a breakpoint
   a_r6_bkpt: assert property (@(posedge clk) disable iff (!rst_n)
      (t2_strobe && !clr_status && live_err == 2'b11) |=> bkpt_latched);

   // R6: a double failure leaves single-half status alone
   a_r6_no_single: assert property (@(posedge clk) disable iff (!rst_n)
      (t2_strobe && !clr_status && live_err == 2'b11) |=> $stable(err_latched));

   // R7: no enable, no halt
   a_r7_need_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_en == 2'b00) |-> !halt);

   // R7: no status, no halt
   a_r7_need_status: assert property (@(posedge clk) disable iff (!rst_n)
      (err_latched == 2'b00 && !bkpt_latched) |-> !halt);

   // R8: a frozen strobe keeps the register contents
   a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (t2_strobe && dbg_mode && live_err != 2'b00) |=> $stable(ir_data));

   // R9: clear wins over set
   a_r9_mode_clr: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_clr |=> !dbg_mode);

   // R11: no strobe, no register change
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !t2_strobe |=> $stable(ir_data));

endmodule

bind ucs_parity_bkpt ucs_parity_bkpt_chk #(.BYTE_W(BYTE_W)) i_chk (.*);

// File: tb/test_ucs_parity_bkpt.sv
`timescale 1ns/1ps
module test_ucs_parity_bkpt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [33:0] wr_data = '0;
   logic [3:0]  wr_bpar = '0;
   logic [1:0]  wr_force_bad = '0;
   logic [5:0]  rd_addr = '0;
   logic        t2_strobe = 1'b0;
   logic [1:0]  halt_en = '0;
   logic        clr_status = 1'b0;
   logic        dbg_set = 1'b0;
   logic        dbg_clr = 1'b0;
   logic [33:0] ir_data;
   logic [1:0]  live_err;
   logic [1:0]  err_latched;
   logic        bkpt_latched;
   logic        halt;
   logic        dbg_mode;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ucs_parity_bkpt i_ucs_parity_bkpt (.*);

   // {force[1:0], corrupt[1:0], exp_live[1:0], data[33:0]}
   localparam logic [39:0] VEC [8] = '{
      {2'b00, 2'b00, 2'b00, 34'h0_0000_0000},
      {2'b00, 2'b00, 2'b00, 34'h3_FFFF_FFFF},
      {2'b01, 2'b00, 2'b01, 34'h1_2345_6789},
      {2'b10, 2'b00, 2'b10, 34'h2_AAAA_5555},
      {2'b11, 2'b00, 2'b11, 34'h0_F0F0_0F0F},
      {2'b00, 2'b01, 2'b01, 34'h3_0001_8000},
      {2'b00, 2'b10, 2'b10, 34'h1_DEAD_BEEF},
      {2'b01, 2'b01, 2'b00, 34'h2_0F1E_2D3C}
   };

   localparam logic [33:0] D10  = 34'h1_5A5A_3C3C;
   localparam logic [33:0] D11  = 34'h0_1357_9BDF;
   localparam logic [33:0] D11B = 34'h2_4444_8001;
   localparam logic [33:0] D12  = 34'h3_7777_0000;

   function automatic logic [3:0] good_bpar(input logic [33:0] d);
      return {~^d[32:25], ~^d[24:17], ~^d[15:8], ~^d[7:0]};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [5:0] a, input logic [33:0] d,
                           input logic [3:0] bp, input logic [1:0] frc);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_bpar = bp; wr_force_bad = frc;
      @(negedge clk);
      wr_en = 1'b0; wr_force_bad = 2'b00;
   endtask

   task automatic do_t2(input logic [5:0] a, input logic clr);
      rd_addr = a; t2_strobe = 1'b1; clr_status = clr;
      @(negedge clk);
      t2_strobe = 1'b0; clr_status = 1'b0;
   endtask

   task automatic pulse_clr();
      clr_status = 1'b1;
      @(negedge clk);
      clr_status = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 ir_data", ir_data, 0);
      chk("R10 live_err", live_err, 0);
      chk("R10 err_latched", err_latched, 0);
      chk("R10 bkpt", bkpt_latched, 0);
      chk("R10 halt", halt, 0);
      chk("R10 dbg_mode", dbg_mode, 0);

      // R1 R2 R3: table of write patterns
      for (int i = 0; i < 8; i++) begin
         logic [33:0] d;
         logic [3:0]  bp;
         d  = VEC[i][33:0];
         bp = good_bpar(d);
         if (VEC[i][36]) bp[0] = ~bp[0];
         if (VEC[i][37]) bp[2] = ~bp[2];
         do_write(6'(i), d, bp, VEC[i][39:38]);
         do_t2(6'(i), 1'b0);
         chk("R1 ir_data", ir_data, d);
         chk("R2 R3 live_err", live_err, VEC[i][35:34]);
      end
      pulse_clr();

      // R4 R5 R7: single-half failure latched one strobe later
      halt_en = 2'b01;
      do_write(6'd10, D10, good_bpar(D10), 2'b01);
      do_write(6'd11, D11, good_bpar(D11), 2'b00);
      do_write(6'd12, D12, good_bpar(D12), 2'b11);
      do_t2(6'd11, 1'b1);
      do_t2(6'd10, 1'b0);
      chk("R4 live now", live_err, 2'b01);
      chk("R4 not latched yet", err_latched, 2'b00);
      chk("R7 halt idle", halt, 0);
      do_t2(6'd11, 1'b0);
      chk("R5 latched", err_latched, 2'b01);
      chk("R4 live clean", live_err, 2'b00);
      chk("R7 halt enabled half", halt, 1);
      @(negedge clk);
      chk("R5 sticky", err_latched, 2'b01);
      halt_en = 2'b10;
      #1;
      chk("R7 other enable only", halt, 0);
      do_t2(6'd10, 1'b0);
      do_t2(6'd11, 1'b1);
      chk("R5 clear wins", err_latched, 2'b00);

      // R6 R7: breakpoint
      do_t2(6'd12, 1'b0);
      chk("R6 live both", live_err, 2'b11);
      do_t2(6'd11, 1'b0);
      chk("R6 bkpt", bkpt_latched, 1);
      chk("R6 no single", err_latched, 2'b00);
      chk("R7 bkpt halt", halt, 1);
      halt_en = 2'b00;
      #1;
      chk("R7 bkpt no enable", halt, 0);
      pulse_clr();
      chk("R5 bkpt cleared", bkpt_latched, 0);

      // R8 R9: debug freeze
      dbg_set = 1'b1;
      @(negedge clk);
      dbg_set = 1'b0;
      chk("R9 set", dbg_mode, 1);
      do_t2(6'd10, 1'b0);
      chk("R8 clean word loads", ir_data, D10);
      do_t2(6'd11, 1'b0);
      chk("R8 frozen", ir_data, D10);
      chk("R8 status still latched", err_latched, 2'b01);
      dbg_set = 1'b1; dbg_clr = 1'b1;
      @(negedge clk);
      dbg_set = 1'b0; dbg_clr = 1'b0;
      chk("R9 clear wins", dbg_mode, 0);
      do_t2(6'd11, 1'b0);
      chk("R8 loads when off", ir_data, D11);
      pulse_clr();

      // R11: write does not touch the register
      do_write(6'd11, D11B, good_bpar(D11B), 2'b00);
      chk("R11 unchanged", ir_data, D11);
      do_t2(6'd11, 1'b0);
      chk("R11 new word", ir_data, D11B);
      chk("R1 new word clean", live_err, 2'b00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule